// File: doc/BRIEF.md
# Baud Clock Generator

This block turns the module clock into the timing strobes that a serial transmitter and receiver need. A 13-bit divisor is split over two byte-wide register locations. The block emits a one-cycle oversampling pulse every `divisor` module clocks, and a bit-rate pulse once for every 16 of those pulses. The serial rate is therefore the module clock divided by 16 times the divisor.

Software reaches the divisor through a small byte bus with one address bit, a write strobe, write data and combinational read data. A write to the high location only fills a staging register. The divisor that drives the counters changes only when the low location is written, so both halves always change at the same time.

The generator does nothing until the transmitter or the receiver has been enabled once after reset. A divisor of zero also stops it. The three top bits of the high location are control bits that take writes only while the special-mode input is high.

Top module: `baud_clkgen`

## Requirements
- R1: After reset, address 0 (high location) reads 0x00, address 1 (low location) reads 0x04, and neither tick output pulses.
- R2: Reads are combinational and allowed at any time. Address 0 returns the staged high byte. Address 1 returns bits 7..0 of the active divisor.
- R3: A write to address 0 leaves the active divisor and the tick period unchanged. The new value is visible at once on address 0.
- R4: A write to address 1 loads the active divisor with {staged bits 4..0, written byte} and restarts both counters.
- R5: Bits 7..5 of address 0 accept writes only while `special_mode` is 1. Otherwise they keep their value. Bits 4..0 accept writes at any time.
- R6: While running, `tick_16x` is a single-cycle pulse, and consecutive pulses are exactly `divisor` clocks apart.
- R7: `tick_bit` is a single-cycle pulse. It comes one clock after every 16th `tick_16x` pulse, so it repeats every 16 × `divisor` clocks.
- R8: No tick is produced until `tx_en` or `rx_en` has been seen high at a clock edge after reset. That condition is then held until reset, even after both enables drop.
- R9: While the active divisor is zero, neither tick output pulses.
- R10: A divisor of 1 gives a `tick_16x` pulse on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 1 | Register select: 0 = high byte, 1 = low byte |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location |
| special_mode | input | 1 | Allows writes to the three control bits of the high byte |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tick_16x | output | 1 | Oversampling pulse, one per divisor period |
| tick_bit | output | 1 | Bit-rate pulse, one per 16 oversampling pulses |

## Verification
The assertions assume that reset is held from time zero and that every input is synchronous to `clk`, with at most one register write per cycle. They also take the internal divisor and the enable flag as the reference for when ticks may appear. The bench changes inputs only just after a falling edge and reads only at falling edges. After each divisor load it waits a few clocks and then judges tick spacing only from pulses that fall completely inside the measurement window. This keeps the partial period around a restart out of the period checks.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DIV_W      = 13;
    localparam int BYTE_W     = 8;
    localparam int OVERSAMPLE = 16;
    localparam int RESET_DIV  = 4;
    localparam logic ADDR_HI  = 1'b0;
    localparam logic ADDR_LO  = 1'b1;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int BW = BYTE_W,
    parameter int RV = RESET_DIV
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_addr,
    input  logic          bus_we,
    input  logic [BW-1:0] bus_wdata,
    input  logic          special_mode,
    output logic [BW-1:0] bus_rdata,
    output logic [BW-1:0] hi_stage,
    output logic [DW-1:0] div_active,
    output logic          load_pulse
);
    localparam int HI_BITS = DW - BW;

    typedef struct packed {
        logic [BW-1:0] hi;
        logic [DW-1:0] div;
        logic          load;
    } reg_state_t;

    reg_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (bus_we && bus_addr == ADDR_HI) begin
            st_d.hi[HI_BITS-1:0] = bus_wdata[HI_BITS-1:0];
            if (special_mode) begin
                st_d.hi[BW-1:HI_BITS] = bus_wdata[BW-1:HI_BITS];
            end
        end
        if (bus_we && bus_addr == ADDR_LO) begin
            st_d.div  = {st_q.hi[HI_BITS-1:0], bus_wdata};
            st_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.hi   <= '0;
            st_q.div  <= DW'(RV);
            st_q.load <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = (bus_addr == ADDR_HI) ? st_q.hi : st_q.div[BW-1:0];
    assign hi_stage   = st_q.hi;
    assign div_active = st_q.div;
    assign load_pulse = st_q.load;
endmodule

// File: rtl/baud_countdown.sv
module baud_countdown #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] period_m1,
    output logic             pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cd_state_t;

    cd_state_t cd_q, cd_d;

    always_comb begin
        cd_d       = cd_q;
        cd_d.pulse = 1'b0;
        if (restart || !run) begin
            cd_d.cnt = period_m1;
        end else if (step) begin
            if (cd_q.cnt == '0) begin
                cd_d.cnt   = period_m1;
                cd_d.pulse = 1'b1;
            end else begin
                cd_d.cnt = cd_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cd_q <= '0;
        end else begin
            cd_q <= cd_d;
        end
    end

    assign pulse = cd_q.pulse;
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              special_mode,
    input  logic              tx_en,
    input  logic              rx_en,
    output logic              tick_16x,
    output logic              tick_bit
);
    localparam int SUB_W = $clog2(OVERSAMPLE);
    localparam logic [SUB_W-1:0] SUB_M1 = SUB_W'(OVERSAMPLE - 1);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [BYTE_W-1:0] hi_stage;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_m1;
    logic              load_q;
    logic              en_seen_q, en_seen_d;
    logic              run;

    baud_regs #(.DW(DIV_W), .BW(BYTE_W), .RV(RESET_DIV)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .special_mode (special_mode),
        .bus_rdata    (bus_rdata),
        .hi_stage     (hi_stage),
        .div_active   (div_q),
        .load_pulse   (load_q)
    );

    always_comb begin
        en_seen_d = en_seen_q | tx_en | rx_en;
        run       = en_seen_q && (div_q != '0);
        div_m1    = div_q - DIV_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_seen_q <= 1'b0;
        end else begin
            en_seen_q <= en_seen_d;
        end
    end

    baud_countdown #(.CNT_W(DIV_W)) u_prescale (
        .clk       (clk),
        .rst       (rst),
        .restart   (load_q),
        .run       (run),
        .step      (1'b1),
        .period_m1 (div_m1),
        .pulse     (tick_16x)
    );

    baud_countdown #(.CNT_W(SUB_W)) u_bitdiv (
        .clk       (clk),
        .rst       (rst),
        .restart   (load_q),
        .run       (run),
        .step      (tick_16x),
        .period_m1 (SUB_M1),
        .pulse     (tick_bit)
    );
endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk
    import baud_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_addr,
    input logic              bus_we,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              special_mode,
    input logic              tick_16x,
    input logic              tick_bit,
    input logic [DIV_W-1:0]  div_q,
    input logic [BYTE_W-1:0] hi_stage,
    input logic              en_seen_q
);
    localparam int HI_BITS = DIV_W - BYTE_W;

    // R3: a high-byte write never moves the active divisor
    p_stage_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_HI) |=> $stable(div_q));

    // R4: a low-byte write loads staged high bits plus the new byte
    p_load_value_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_LO) |=>
            div_q == {$past(hi_stage[HI_BITS-1:0]), $past(bus_wdata)});

    // R5: control bits hold outside special mode
    p_ctl_locked_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_HI && !special_mode) |=>
            hi_stage[BYTE_W-1:HI_BITS] == $past(hi_stage[BYTE_W-1:HI_BITS]));

    // R6: oversampling pulse lasts one cycle when the divisor exceeds one
    p_tick_single_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_16x && div_q > DIV_W'(1)) |=> !tick_16x);

    // R7: a bit pulse follows an oversampling pulse and never repeats at once
    p_bit_follows_r7: assert property (@(posedge clk) disable iff (rst)
        tick_bit |-> $past(tick_16x));
    p_bit_single_r7: assert property (@(posedge clk) disable iff (rst)
        tick_bit |=> !tick_bit);

    // R8: no tick before an enable has been seen, and the flag is sticky
    p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
        !en_seen_q |=> !tick_16x && !tick_bit);
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        en_seen_q |=> en_seen_q);

    // R9: zero divisor stops the oversampling pulse
    p_zero_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (div_q == '0) |=> !tick_16x);
endmodule

bind baud_clkgen baud_clkgen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .special_mode (special_mode),
    .tick_16x     (tick_16x),
    .tick_bit     (tick_bit),
    .div_q        (div_q),
    .hi_stage     (hi_stage),
    .en_seen_q    (en_seen_q)
);

// File: tb/baud_clkgen_tb.sv
module baud_clkgen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       special_mode = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       tick_16x;
    logic       tick_bit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int obs16[$];
    int obsb[$];

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t rd_q[$];
    bit rd_pending = 1'b0;

    always #4 clk = ~clk;

    baud_clkgen u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .special_mode (special_mode),
        .tx_en        (tx_en),
        .rx_en        (rx_en),
        .tick_16x     (tick_16x),
        .tick_bit     (tick_bit)
    );

    // monitor: records tick times and pops expected reads from the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (tick_16x === 1'b1) obs16.push_back(cyc);
        if (tick_bit === 1'b1) obsb.push_back(cyc);
        if (rd_pending && rd_q.size() > 0) begin
            rd_item_t it;
            it = rd_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s rdata actual %02h expected %02h", it.tag, bus_rdata, it.exp);
            end
            rd_pending = 1'b0;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] e, input string tag);
        rd_item_t it;
        @(negedge clk); #1;
        bus_addr = a;
        it.exp = e; it.tag = tag;
        rd_q.push_back(it);
        rd_pending = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic check_gaps(ref int q[$], input int p, input int window,
                              input string name, input string tag);
        int ok = 1;
        int bad = p;
        idle(4);
        q.delete();
        idle(window);
        if (q.size() < 2) begin
            ok = 0; bad = -1;
        end else begin
            for (int i = 1; i < q.size(); i++) begin
                if (q[i] - q[i-1] != p) begin ok = 0; bad = q[i] - q[i-1]; end
            end
        end
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s interval actual %0d expected %0d (pulses %0d)",
                     tag, name, bad, p, q.size());
        end
    endtask

    task automatic check_none(input int window, input string tag);
        idle(1);
        obs16.delete(); obsb.delete();
        idle(window);
        checks++;
        if (obs16.size() != 0 || obsb.size() != 0) begin
            errors++;
            $display("FAIL %s tick pulses actual %0d/%0d expected 0/0",
                     tag, obs16.size(), obsb.size());
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state, R8 gated before any enable
        rd(1'b0, 8'h00, "R1");
        rd(1'b1, 8'h04, "R1");
        check_none(40, "R1");
        check_none(20, "R8");

        // R8 enable for one cycle only, then sticky
        @(negedge clk); #1; tx_en = 1'b1;
        @(negedge clk); #1; tx_en = 1'b0;
        check_gaps(obs16, 4, 60, "tick_16x", "R6");
        check_gaps(obsb, 64, 300, "tick_bit", "R7");

        // R5 control bits locked, R3 staged value not active
        wr(1'b0, 8'hFF);
        rd(1'b0, 8'h1F, "R5");
        check_gaps(obs16, 4, 40, "tick_16x", "R3");
        rd(1'b1, 8'h04, "R2");

        special_mode = 1'b1;
        wr(1'b0, 8'hE0);
        special_mode = 1'b0;
        rd(1'b0, 8'hE0, "R5");
        wr(1'b0, 8'h01);
        rd(1'b0, 8'hE1, "R5");

        // R4 load of {00001, 00000000} = 256
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h00, "R2");
        check_gaps(obs16, 256, 900, "tick_16x", "R4");

        wr(1'b0, 8'hE0);
        rd(1'b0, 8'hE0, "R5");
        wr(1'b1, 8'h03);
        check_gaps(obs16, 3, 40, "tick_16x", "R4");
        check_gaps(obsb, 48, 200, "tick_bit", "R7");

        // R9 divisor zero
        wr(1'b1, 8'h00);
        check_none(60, "R9");

        // R10 divisor one
        wr(1'b1, 8'h01);
        check_gaps(obs16, 1, 40, "tick_16x", "R10");
        check_gaps(obsb, 16, 100, "tick_bit", "R7");

        // R8 after a new reset, receiver enable alone starts the generator
        do_reset();
        rd(1'b0, 8'h00, "R1");
        rd(1'b1, 8'h04, "R1");
        check_none(40, "R8");
        @(negedge clk); #1; rx_en = 1'b1;
        @(negedge clk); #1; rx_en = 1'b0;
        check_gaps(obs16, 4, 60, "tick_16x", "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule